// File: doc/BRIEF.md
# Router Power-Gating State Controller

This block decides the power state of a single on-chip router. It gates the router off once its datapath has drained, warns the neighbouring routers before it does so, and powers the router back up when there is demand. While the router is dark, and for the whole time it is coming back up, local traffic is sent through bypass ports. Because of this, a wakeup never stalls the node.

There are two wake policies. In decoupled mode, the controller counts network-interface virtual-channel requests over a sliding window. It wakes the router when that count rises strictly above a threshold. A static class input picks between two programmed thresholds: a low one for performance-critical routers and a high one for power-oriented routers. In conventional mode, a wake request from any neighbour starts the wakeup.

The block also keeps two statistics. A wrapping counter records how many wakeups have been performed. A one-cycle flag marks every off period that ended before the breakeven interval, because such a period costs more energy than it saves.

Top module: `rpg_ctrl`

## Requirements
- R1: During and right after a synchronous reset, the controller is in the powered state. `pwr_en`=1, `pg_out`=0, `byp_en`=0, `wake_cnt`=0, `short_off`=0, and the request window is empty.
- R2: In the powered state (`pwr_en`=1, `pg_out`=0, `byp_en`=0), the controller stays powered while `dp_empty`=0 or while wake demand is present. When `dp_empty`=1 and there is no demand at a clock edge, it moves to the notify state.
- R3: The notify state drives `pwr_en`=1, `pg_out`=1, `byp_en`=0. At an edge, demand returns it to the powered state. Without demand, `dp_empty`=1 takes it to the gated state, and `dp_empty`=0 keeps it in notify. The gated state can be entered only from notify.
- R4: The gated state drives `pwr_en`=0, `pg_out`=1, `byp_en`=1, and it is held until demand appears.
- R5: In decoupled mode (`mode_conv`=0), the request rate is the number of cycles with `vc_req`=1 among the last WIN_LEN sampled edges. Demand means that rate is strictly greater than the selected threshold.
- R6: `perf_class`=1 selects `thr_perf` as the threshold, and `perf_class`=0 selects `thr_power`.
- R7: In conventional mode (`mode_conv`=1), demand is the OR of all `nbr_wu` bits, and the request rate has no effect. In decoupled mode, `nbr_wu` has no effect.
- R8: Demand in the gated state starts a wakeup. The wakeup lasts exactly WAKE_CYC cycles with `pwr_en`=1, `pg_out`=1, `byp_en`=1, and demand is ignored during it. After that, the controller returns to the powered state and `pg_out` clears.
- R9: `wake_cnt` increases by one on every gated-to-waking transition and wraps modulo 2^WCNT_W.
- R10: `short_off` is high for exactly the first waking cycle when the preceding gated period lasted fewer than BET_CYC cycles. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_conv | input | 1 | 1: neighbour-driven wake; 0: rate-driven wake |
| perf_class | input | 1 | Static router class, 1 = performance-centric |
| thr_perf | input | THR_W | Rate threshold for the performance class |
| thr_power | input | THR_W | Rate threshold for the power class |
| dp_empty | input | 1 | Router datapath holds no flits |
| vc_req | input | 1 | VC request seen at the local network interface this cycle |
| nbr_wu | input | NBR | Wake requests from neighbouring routers |
| pwr_en | output | 1 | Router supply enable |
| pg_out | output | 1 | Gated/not-ready status to neighbours |
| byp_en | output | 1 | Steer local traffic through the bypass ports |
| wake_cnt | output | WCNT_W | Wrapping count of wakeups performed |
| short_off | output | 1 | Pulse: last off period was below breakeven |

## Verification
The bench builds the controller with an 8-cycle window, 4-bit thresholds, a 4-cycle wakeup, a 5-cycle breakeven interval, two neighbours and a 4-bit wakeup counter. The window is this small so that every threshold from 0 to 8 can be swept against every request burst length from 0 to 8. Off periods from 1 to 7 cycles then fall on both sides of the breakeven limit, and the counter wraps many times during a long mixed-mode pseudo-random run. The threshold-select sweeps and both wake policies are then compared, cycle by cycle, with an arithmetic model of the requirements.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    typedef enum logic [1:0] {
        ST_ON    = 2'd0,
        ST_DRAIN = 2'd1,
        ST_OFF   = 2'd2,
        ST_WAKE  = 2'd3
    } pg_state_e;

    typedef struct packed {
        logic pwr;
        logic pg;
        logic byp;
    } pg_ctl_t;

    function automatic pg_ctl_t decode_ctl(pg_state_e s);
        pg_ctl_t c;
        c.pwr = (s != ST_OFF);
        c.pg  = (s != ST_ON);
        c.byp = (s == ST_OFF) || (s == ST_WAKE);
        return c;
    endfunction

endpackage

// File: rtl/rpg_rate_win.sv
module rpg_rate_win #(
    parameter int WIN_LEN = 32,
    localparam int RATE_W = $clog2(WIN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    output logic [RATE_W-1:0] rate_o
);
    logic [WIN_LEN-1:0] hist_q;
    logic [RATE_W-1:0]  rate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            rate_q <= '0;
        end else begin
            hist_q <= {hist_q[WIN_LEN-2:0], req_i};
            rate_q <= rate_q + RATE_W'(req_i) - RATE_W'(hist_q[WIN_LEN-1]);
        end
    end

    assign rate_o = rate_q;

    // R5
    rate_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rate_q <= RATE_W'(WIN_LEN));

    // R5
    rate_step_chk: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> rate_q <= $past(rate_q));

endmodule

// File: rtl/rpg_fsm.sv
module rpg_fsm
    import rpg_pkg::*;
#(
    parameter int WAKE_CYC = 12,
    localparam int CD_W = $clog2(WAKE_CYC + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      dp_empty_i,
    input  logic      demand_i,
    output pg_state_e state_o,
    output logic      wake_start_o,
    output logic      off_enter_o
);
    pg_state_e       state_q, state_d;
    logic [CD_W-1:0] cd_q, cd_d;

    always_comb begin
        state_d      = state_q;
        cd_d         = cd_q;
        wake_start_o = 1'b0;
        off_enter_o  = 1'b0;
        unique case (state_q)
            ST_ON: begin
                if (dp_empty_i && !demand_i) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (demand_i) begin
                    state_d = ST_ON;
                end else if (dp_empty_i) begin
                    state_d     = ST_OFF;
                    off_enter_o = 1'b1;
                end
            end
            ST_OFF: begin
                if (demand_i) begin
                    state_d      = ST_WAKE;
                    cd_d         = CD_W'(WAKE_CYC - 1);
                    wake_start_o = 1'b1;
                end
            end
            ST_WAKE: begin
                if (cd_q == '0) state_d = ST_ON;
                else            cd_d = cd_q - CD_W'(1);
            end
            default: state_d = ST_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ON;
            cd_q    <= '0;
        end else begin
            state_q <= state_d;
            cd_q    <= cd_d;
        end
    end

    assign state_o = state_q;

    // R3
    off_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_OFF) |-> ($past(state_q) == ST_DRAIN) && $past(dp_empty_i));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ON) && !dp_empty_i |=> state_q == ST_ON);

    // R8
    wake_done_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAKE) && (cd_q == '0) |=> state_q == ST_ON);

    // R8
    wake_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_WAKE) |-> cd_q == CD_W'(WAKE_CYC - 1));

endmodule

// File: rtl/rpg_stats.sv
module rpg_stats #(
    parameter int WCNT_W  = 16,
    parameter int BET_CYC = 10,
    localparam int OFF_W  = $clog2(BET_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_off_i,
    input  logic              off_enter_i,
    input  logic              wake_start_i,
    output logic [WCNT_W-1:0] wake_cnt_o,
    output logic              short_off_o
);
    logic [OFF_W-1:0]  off_cnt_q;
    logic [WCNT_W-1:0] wake_cnt_q;
    logic              short_off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_cnt_q   <= '0;
            wake_cnt_q  <= '0;
            short_off_q <= 1'b0;
        end else begin
            short_off_q <= wake_start_i && (off_cnt_q < OFF_W'(BET_CYC));
            if (wake_start_i) wake_cnt_q <= wake_cnt_q + WCNT_W'(1);
            if (off_enter_i)
                off_cnt_q <= OFF_W'(1);
            else if (in_off_i && (off_cnt_q < OFF_W'(BET_CYC)))
                off_cnt_q <= off_cnt_q + OFF_W'(1);
        end
    end

    assign wake_cnt_o  = wake_cnt_q;
    assign short_off_o = short_off_q;

    // R9
    wake_step_chk: assert property (@(posedge clk) disable iff (rst)
        wake_start_i |=> wake_cnt_q == $past(wake_cnt_q) + WCNT_W'(1));

    // R9
    wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wake_start_i |=> $stable(wake_cnt_q));

    // R10
    short_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        short_off_q |=> !short_off_q);

endmodule

// File: rtl/rpg_ctrl.sv
module rpg_ctrl
    import rpg_pkg::*;
#(
    parameter int WIN_LEN  = 32,
    parameter int THR_W    = 6,
    parameter int WAKE_CYC = 12,
    parameter int BET_CYC  = 10,
    parameter int NBR      = 4,
    parameter int WCNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_conv,
    input  logic              perf_class,
    input  logic [THR_W-1:0]  thr_perf,
    input  logic [THR_W-1:0]  thr_power,
    input  logic              dp_empty,
    input  logic              vc_req,
    input  logic [NBR-1:0]    nbr_wu,
    output logic              pwr_en,
    output logic              pg_out,
    output logic              byp_en,
    output logic [WCNT_W-1:0] wake_cnt,
    output logic              short_off
);
    localparam int RATE_W = $clog2(WIN_LEN + 1);
    localparam int CMP_W  = (RATE_W > THR_W) ? RATE_W : THR_W;

    logic [RATE_W-1:0] rate;
    logic [THR_W-1:0]  thr_sel;
    logic              rate_hit, demand;
    logic              wake_start, off_enter;
    pg_state_e         state;
    pg_ctl_t           ctl;

    rpg_rate_win #(.WIN_LEN(WIN_LEN)) u_win (
        .clk    (clk),
        .rst    (rst),
        .req_i  (vc_req),
        .rate_o (rate)
    );

    assign thr_sel  = perf_class ? thr_perf : thr_power;
    assign rate_hit = CMP_W'(rate) > CMP_W'(thr_sel);
    assign demand   = mode_conv ? (|nbr_wu) : rate_hit;

    rpg_fsm #(.WAKE_CYC(WAKE_CYC)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .dp_empty_i   (dp_empty),
        .demand_i     (demand),
        .state_o      (state),
        .wake_start_o (wake_start),
        .off_enter_o  (off_enter)
    );

    rpg_stats #(.WCNT_W(WCNT_W), .BET_CYC(BET_CYC)) u_stats (
        .clk          (clk),
        .rst          (rst),
        .in_off_i     (state == ST_OFF),
        .off_enter_i  (off_enter),
        .wake_start_i (wake_start),
        .wake_cnt_o   (wake_cnt),
        .short_off_o  (short_off)
    );

    assign ctl    = decode_ctl(state);
    assign pwr_en = ctl.pwr;
    assign pg_out = ctl.pg;
    assign byp_en = ctl.byp;

    // R4
    gate_pg_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |-> pg_out);

    // R8
    bypass_pg_chk: assert property (@(posedge clk) disable iff (rst)
        byp_en |-> pg_out);

    // R7
    conv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_en && mode_conv && !(|nbr_wu) |=> !pwr_en);

    // R10
    short_src_chk: assert property (@(posedge clk) disable iff (rst)
        short_off |-> byp_en && pwr_en);

endmodule

// File: tb/rpg_ctrl_test.sv
`timescale 1ns/1ps
module rpg_ctrl_test;
    localparam int WIN  = 8;
    localparam int THRW = 4;
    localparam int WAKE = 4;
    localparam int BET  = 5;
    localparam int NB   = 2;
    localparam int WCW  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_conv = 1'b0, perf_class = 1'b1;
    logic [THRW-1:0] thr_perf = '0, thr_power = '0;
    logic dp_empty = 1'b1, vc_req = 1'b0;
    logic [NB-1:0] nbr_wu = '0;
    logic pwr_en, pg_out, byp_en, short_off;
    logic [WCW-1:0] wake_cnt;

    always #2 clk = ~clk;

    rpg_ctrl #(.WIN_LEN(WIN), .THR_W(THRW), .WAKE_CYC(WAKE), .BET_CYC(BET),
               .NBR(NB), .WCNT_W(WCW)) uut (
        .clk(clk), .rst(rst), .mode_conv(mode_conv), .perf_class(perf_class),
        .thr_perf(thr_perf), .thr_power(thr_power), .dp_empty(dp_empty),
        .vc_req(vc_req), .nbr_wu(nbr_wu), .pwr_en(pwr_en), .pg_out(pg_out),
        .byp_en(byp_en), .wake_cnt(wake_cnt), .short_off(short_off));

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    string phase = "R1";

    // requirement model: 0 powered, 1 notify, 2 gated, 3 waking
    int mst = 0, mwk = 0, moff = 0, mcount = 0;
    bit mshort = 0;
    logic [WIN-1:0] mh = '0;

    task automatic chk(bit ok, string req, int act, int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, expv);
        end
    endtask

    task automatic model_edge();
        bit dem;
        int thr;
        if (rst) begin
            mst = 0; mwk = 0; moff = 0; mcount = 0; mshort = 0; mh = '0;
        end else begin
            thr = perf_class ? int'(thr_perf) : int'(thr_power);
            dem = mode_conv ? (nbr_wu != '0) : ($countones(mh) > thr);
            mshort = 0;
            case (mst)
                0: if (dp_empty && !dem) mst = 1;
                1: if (dem) mst = 0;
                   else if (dp_empty) begin mst = 2; moff = 1; end
                2: if (dem) begin
                       mst = 3; mwk = WAKE; mshort = (moff < BET);
                       mcount = (mcount + 1) % (1 << WCW);
                   end else moff++;
                default: begin mwk--; if (mwk == 0) mst = 0; end
            endcase
            mh = {mh[WIN-2:0], vc_req};
        end
    endtask

    task automatic compare();
        string sreq;
        case (mst)
            0: sreq = "R2"; 1: sreq = "R3"; 2: sreq = "R4"; default: sreq = "R8";
        endcase
        chk(pwr_en == (mst != 2), {sreq, " pwr_en"}, int'(pwr_en), int'(mst != 2));
        chk(pg_out == (mst != 0), {sreq, " pg_out"}, int'(pg_out), int'(mst != 0));
        chk(byp_en == (mst >= 2), {sreq, " byp_en"}, int'(byp_en), int'(mst >= 2));
        chk(int'(wake_cnt) == mcount, "R9 wake_cnt", int'(wake_cnt), mcount);
        chk(short_off == mshort, "R10 short_off", int'(short_off), int'(mshort));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        #1;
        compare();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) cyc();
        rst = 1'b0;
    endtask

    task automatic wait_off();
        while (mst != 2) cyc();
    endtask

    // decoupled burst: k requests while gated, expect wake iff k > threshold
    task automatic burst_run(int k, int thr_eff, string req);
        do_reset();
        vc_req = 1'b0; dp_empty = 1'b1;
        wait_off();
        for (int i = 0; i < k; i++) begin vc_req = 1'b1; cyc(); end
        vc_req = 1'b0;
        repeat (WIN + WAKE + 8) cyc();
        chk(int'(wake_cnt) == ((k > thr_eff) ? 1 : 0), req, int'(wake_cnt),
            (k > thr_eff) ? 1 : 0);
    endtask

    initial begin
        logic [15:0] lfsr;
        // R1: reset state
        phase = "R1";
        rst = 1'b1;
        repeat (3) cyc();
        chk(pwr_en == 1'b1 && pg_out == 1'b0 && byp_en == 1'b0, "R1 ctl",
            int'({pwr_en, pg_out, byp_en}), 4);
        chk(wake_cnt == '0 && short_off == 1'b0, "R1 stats",
            int'(wake_cnt), 0);
        rst = 1'b0;

        // R2: busy datapath keeps router powered
        phase = "R2";
        dp_empty = 1'b0;
        repeat (10) cyc();
        chk(pg_out == 1'b0, "R2 busy stays on", int'(pg_out), 0);
        dp_empty = 1'b1; cyc();
        chk(pg_out == 1'b1 && pwr_en == 1'b1, "R2 to notify", int'(pg_out), 1);

        // R3: notify holds while busy, demand cancels gating
        phase = "R3";
        dp_empty = 1'b0; repeat (4) cyc();
        chk(pwr_en == 1'b1 && pg_out == 1'b1, "R3 notify hold", int'(pg_out), 1);
        mode_conv = 1'b1; nbr_wu = 2'b01; cyc();
        chk(pg_out == 1'b0, "R3 demand back on", int'(pg_out), 0);
        nbr_wu = '0; dp_empty = 1'b1; repeat (2) cyc();
        chk(pwr_en == 1'b0, "R3 gate after drain", int'(pwr_en), 0);
        mode_conv = 1'b0;

        // R5: every threshold against every burst length
        phase = "R5";
        perf_class = 1'b1; thr_power = 4'd15;
        for (int t = 0; t <= WIN; t++) begin
            thr_perf = THRW'(t);
            for (int k = 0; k <= WIN; k++) burst_run(k, t, "R5 wake vs rate");
        end

        // R6: class selects threshold
        phase = "R6";
        thr_perf = 4'd2; thr_power = 4'd6;
        for (int c = 0; c < 2; c++) begin
            perf_class = c[0];
            for (int k = 0; k <= WIN; k++)
                burst_run(k, (c == 1) ? 2 : 6, "R6 class threshold");
        end

        // R7: conventional mode ignores rate; decoupled ignores neighbours
        phase = "R7";
        for (int w = 0; w < (1 << NB); w++) begin
            do_reset();
            mode_conv = 1'b1; thr_perf = '0; perf_class = 1'b1;
            vc_req = 1'b1; dp_empty = 1'b1;
            wait_off();
            repeat (12) cyc();
            chk(pwr_en == 1'b0, "R7 rate ignored", int'(pwr_en), 0);
            nbr_wu = NB'(w); cyc(); nbr_wu = '0;
            chk(pwr_en == (w != 0), "R7 neighbour wake", int'(pwr_en), int'(w != 0));
            repeat (WAKE + 4) cyc();
            vc_req = 1'b0;
        end
        do_reset();
        mode_conv = 1'b0; thr_perf = 4'd8; vc_req = 1'b0;
        wait_off();
        nbr_wu = '1; repeat (10) cyc(); nbr_wu = '0;
        chk(pwr_en == 1'b0, "R7 neighbours ignored", int'(pwr_en), 0);

        // R8 / R10: off lengths around breakeven in conventional mode
        phase = "R10";
        mode_conv = 1'b1;
        for (int d = 1; d <= BET + 2; d++) begin
            do_reset();
            dp_empty = 1'b1;
            wait_off();
            repeat (d - 1) cyc();
            nbr_wu = 2'b10; cyc(); nbr_wu = '0;
            chk(short_off == (d < BET), "R10 short flag", int'(short_off), int'(d < BET));
            phase = "R8";
            repeat (WAKE - 1) cyc();
            chk(byp_en == 1'b1, "R8 bypass in last wake cycle", int'(byp_en), 1);
            dp_empty = 1'b0; cyc();
            chk(pg_out == 1'b0 && byp_en == 1'b0, "R8 back on", int'(pg_out), 0);
            phase = "R10";
        end

        // mixed pseudo-random run: R9 wrap and all transitions
        phase = "R9";
        do_reset();
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i % 500 == 0) begin
                mode_conv = lfsr[3]; perf_class = lfsr[5];
                thr_perf = THRW'(lfsr[8:6]); thr_power = THRW'(lfsr[11:9]) + 4'd2;
            end
            dp_empty = (lfsr[2:0] != 3'd0);
            vc_req   = lfsr[4] & lfsr[9];
            nbr_wu   = (lfsr[7:4] == 4'd0) ? NB'(lfsr[1:0]) : '0;
            cyc();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog [%s] actual=%0d expected=%0d", phase, 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule